// File: doc/BRIEF.md
# Double-Confirm Converter Enable Controller

This block sits behind a two-wire management bus slave that controls a DC/DC converter. The slave decodes each completed transaction and hands this block one-cycle event pulses. The events are: a Setup write carrying two five-bit divider codes, an On command, an Off command, a read of this device, and a completed transaction to some other device. From these pulses and two board-level inputs (an external run enable and a code select), the block keeps the bus-side enable flag. It also holds the two divider-code registers, guards them against writes while the converter runs, and drives the active code and the two read-back bytes.

Every change of the bus-side enable flag needs two matching commands to this device back to back. A protocol of any other kind to this device between them cancels the half-finished pair. Traffic to other devices is invisible to the pair logic. On commands have no effect until a Setup has loaded the codes at least once. While the converter is running, the codes are frozen.

Top module: `conv_enable_ctrl`

## Requirements
- R1: After reset, `smb_on_o` and `conv_run_o` are 0, both code registers hold 0, and the read-back status bit is 1.
- R2: After at least one Setup, two On events to this device with no other event to this device between them set `smb_on_o` on the clock edge of the second On.
- R3: A single On does not set `smb_on_o`. A Setup, Read or Off event between two On events cancels the pending On, so the later On only starts a new pair.
- R4: Two consecutive Off events to this device clear `smb_on_o` on the edge of the second Off. An On, Setup or Read event between them cancels the pending Off.
- R5: `ev_foreign_i` pulses change no state and do not cancel a pending On or Off pair.
- R6: Before the first Setup event after reset, On events are ignored: any number of them leaves `smb_on_o` at 0.
- R7: `reg_wr_en_o` is high during a Setup pulse unless both `smb_on_o` and `vr_en_i` are high. Only when it is high are the two codes loaded, low code into register 0 and high code into register 1. Clearing `vr_en_i` or clearing `smb_on_o` (two Off events) re-opens writes.
- R8: `active_code_o` shows register 1 when `sel_hi_i` is 1 and register 0 when it is 0, combinationally.
- R9: `conv_run_o` is `smb_on_o` AND `vr_en_i`. Each read-back byte carries its register's code in bits [7:3], the inverse of `conv_run_o` in bit 2 (0 = running, 1 = stopped), and 0 in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_setup_i | input | 1 | One-cycle pulse: Setup write to this device completed |
| ev_on_i | input | 1 | One-cycle pulse: On command to this device completed |
| ev_off_i | input | 1 | One-cycle pulse: Off command to this device completed |
| ev_read_i | input | 1 | One-cycle pulse: read of this device completed |
| ev_foreign_i | input | 1 | One-cycle pulse: transaction to another device completed |
| setup_lo_code_i | input | CODE_W | Code for register 0, valid with `ev_setup_i` |
| setup_hi_code_i | input | CODE_W | Code for register 1, valid with `ev_setup_i` |
| vr_en_i | input | 1 | External converter run enable |
| sel_hi_i | input | 1 | Selects register 1 (high) or register 0 (low) as active code |
| smb_on_o | output | 1 | Bus-side enable flag |
| conv_run_o | output | 1 | Converter run command |
| reg_wr_en_o | output | 1 | Code register write strobe |
| active_code_o | output | CODE_W | Selected divider code |
| rd_lo_byte_o | output | CODE_W+1+PAD_W | Read-back byte for register 0 |
| rd_hi_byte_o | output | CODE_W+1+PAD_W | Read-back byte for register 1 |

## Verification
A corrupted pair state cannot be seen until the next On or Off event. A lost pending half then shows as `smb_on_o` failing to change on the second command. A stale pending half shows as `smb_on_o` changing on the first one. Either fault appears at the port one edge after the deciding event. A wrong lock shows in the same cycle on `reg_wr_en_o` during a Setup pulse, and a cycle later on `active_code_o` and the read-back bytes. The bench therefore puts a check after each command of every sequence, not only at the end.

// File: rtl/cec_pkg.sv
package cec_pkg;
  typedef enum logic [1:0] {
    PAIR_IDLE     = 2'd0,
    PAIR_ON_HALF  = 2'd1,
    PAIR_OFF_HALF = 2'd2
  } pair_state_e;

  localparam int unsigned NUM_CODE_REGS = 2;
endpackage

// File: rtl/cec_rst_sync.sv
module cec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cec_pair_fsm.sv
module cec_pair_fsm
  import cec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_setup,
  input  logic ev_on,
  input  logic ev_off,
  input  logic ev_read,
  input  logic ev_foreign,
  output logic smb_on,
  output logic setup_done
);
  pair_state_e state_q, state_d;
  logic        smb_on_q, smb_on_d;
  logic        done_q, done_d;
  logic        any_ours;
  logic        upd_en;

  // Foreign traffic is deliberately left out of the update enable.
  assign any_ours = ev_setup | ev_on | ev_off | ev_read;
  assign upd_en   = any_ours;

  always_comb begin
    state_d  = state_q;
    smb_on_d = smb_on_q;
    done_d   = done_q | ev_setup;
    if (ev_off) begin
      if (state_q == PAIR_OFF_HALF) begin
        smb_on_d = 1'b0;
        state_d  = PAIR_IDLE;
      end else begin
        state_d  = PAIR_OFF_HALF;
      end
    end else if (ev_on) begin
      if (!done_q) begin
        state_d = PAIR_IDLE;
      end else if (state_q == PAIR_ON_HALF) begin
        smb_on_d = 1'b1;
        state_d  = PAIR_IDLE;
      end else begin
        state_d  = PAIR_ON_HALF;
      end
    end else if (ev_setup || ev_read) begin
      state_d = PAIR_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PAIR_IDLE;
      smb_on_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (upd_en) begin
      state_q  <= state_d;
      smb_on_q <= smb_on_d;
      done_q   <= done_d;
    end
  end

  assign smb_on     = smb_on_q;
  assign setup_done = done_q;
endmodule

// File: rtl/cec_code_store.sv
module cec_code_store
  import cec_pkg::*;
#(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned PAD_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_setup,
  input  logic [CODE_W-1:0]         lo_code,
  input  logic [CODE_W-1:0]         hi_code,
  input  logic                      lock,
  input  logic                      sel_hi,
  input  logic                      run,
  output logic                      wr_en,
  output logic [CODE_W-1:0]         active_code,
  output logic [CODE_W+PAD_W:0]     rd_lo_byte,
  output logic [CODE_W+PAD_W:0]     rd_hi_byte
);
  logic [CODE_W-1:0] wdata [NUM_CODE_REGS];
  logic [CODE_W-1:0] regs_q [NUM_CODE_REGS];
  logic [CODE_W-1:0] regs_d [NUM_CODE_REGS];
  logic              status_bit;

  assign wr_en      = ev_setup & ~lock;
  assign wdata[0]   = lo_code;
  assign wdata[1]   = hi_code;
  assign status_bit = ~run;

  for (genvar g = 0; g < NUM_CODE_REGS; g++) begin : g_reg
    always_comb begin
      regs_d[g] = wdata[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_en) begin
        regs_q[g] <= regs_d[g];
      end
    end
  end

  assign active_code = sel_hi ? regs_q[1] : regs_q[0];
  assign rd_lo_byte  = {regs_q[0], status_bit, {PAD_W{1'b0}}};
  assign rd_hi_byte  = {regs_q[1], status_bit, {PAD_W{1'b0}}};
endmodule

// File: rtl/conv_enable_ctrl.sv
module conv_enable_ctrl #(
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned PAD_W     = 2,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_setup_i,
  input  logic                  ev_on_i,
  input  logic                  ev_off_i,
  input  logic                  ev_read_i,
  input  logic                  ev_foreign_i,
  input  logic [CODE_W-1:0]     setup_lo_code_i,
  input  logic [CODE_W-1:0]     setup_hi_code_i,
  input  logic                  vr_en_i,
  input  logic                  sel_hi_i,
  output logic                  smb_on_o,
  output logic                  conv_run_o,
  output logic                  reg_wr_en_o,
  output logic [CODE_W-1:0]     active_code_o,
  output logic [CODE_W+PAD_W:0] rd_lo_byte_o,
  output logic [CODE_W+PAD_W:0] rd_hi_byte_o
);
  logic rst_n_sync;
  logic smb_on;
  logic setup_done;
  logic run;

  cec_rst_sync #(.STAGES(RST_STAGE)) rst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  cec_pair_fsm pair_i (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .ev_setup  (ev_setup_i),
    .ev_on     (ev_on_i),
    .ev_off    (ev_off_i),
    .ev_read   (ev_read_i),
    .ev_foreign(ev_foreign_i),
    .smb_on    (smb_on),
    .setup_done(setup_done)
  );

  assign run = smb_on & vr_en_i;

  cec_code_store #(.CODE_W(CODE_W), .PAD_W(PAD_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .ev_setup   (ev_setup_i),
    .lo_code    (setup_lo_code_i),
    .hi_code    (setup_hi_code_i),
    .lock       (run),
    .sel_hi     (sel_hi_i),
    .run        (run),
    .wr_en      (reg_wr_en_o),
    .active_code(active_code_o),
    .rd_lo_byte (rd_lo_byte_o),
    .rd_hi_byte (rd_hi_byte_o)
  );

  assign smb_on_o   = smb_on;
  assign conv_run_o = run;
endmodule

// File: rtl/conv_enable_chk.sv
module conv_enable_chk #(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned PAD_W  = 2
) (
  input logic                  clk,
  input logic                  rst_n_sync,
  input logic                  ev_setup_i,
  input logic                  ev_on_i,
  input logic                  ev_off_i,
  input logic                  ev_read_i,
  input logic                  ev_foreign_i,
  input logic                  vr_en_i,
  input logic                  smb_on_o,
  input logic                  conv_run_o,
  input logic                  reg_wr_en_o,
  input logic [CODE_W+PAD_W:0] rd_lo_byte_o,
  input logic [CODE_W+PAD_W:0] rd_hi_byte_o
);
  logic seen_setup;
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) seen_setup <= 1'b0;
    else if (ev_setup_i) seen_setup <= 1'b1;
  end

  p_rise_after_on_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(smb_on_o) |-> $past(ev_on_i));
  p_fall_after_off_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(smb_on_o) |-> $past(ev_off_i));
  p_foreign_inert_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ev_foreign_i && !ev_setup_i && !ev_on_i && !ev_off_i && !ev_read_i) |=> $stable(smb_on_o));
  p_on_needs_setup_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(smb_on_o) |-> seen_setup);
  p_no_write_running_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ev_setup_i && smb_on_o && vr_en_i) |-> !reg_wr_en_o);
  p_codes_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (smb_on_o && vr_en_i) |=> (rd_lo_byte_o[CODE_W+PAD_W:PAD_W+1] == $past(rd_lo_byte_o[CODE_W+PAD_W:PAD_W+1])
                             && rd_hi_byte_o[CODE_W+PAD_W:PAD_W+1] == $past(rd_hi_byte_o[CODE_W+PAD_W:PAD_W+1])));
  p_status_inverse_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_lo_byte_o[PAD_W] != conv_run_o) && (rd_hi_byte_o[PAD_W] != conv_run_o));
endmodule

bind conv_enable_ctrl conv_enable_chk #(.CODE_W(CODE_W), .PAD_W(PAD_W)) chk_i (
  .clk         (clk),
  .rst_n_sync  (rst_n_sync),
  .ev_setup_i  (ev_setup_i),
  .ev_on_i     (ev_on_i),
  .ev_off_i    (ev_off_i),
  .ev_read_i   (ev_read_i),
  .ev_foreign_i(ev_foreign_i),
  .vr_en_i     (vr_en_i),
  .smb_on_o    (smb_on_o),
  .conv_run_o  (conv_run_o),
  .reg_wr_en_o (reg_wr_en_o),
  .rd_lo_byte_o(rd_lo_byte_o),
  .rd_hi_byte_o(rd_hi_byte_o)
);

// File: tb/conv_enable_ctrl_tb_top.sv
module conv_enable_ctrl_tb_top;
  localparam int CODE_W = 5;
  localparam int PAD_W  = 2;
  localparam int BW     = CODE_W + PAD_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_setup = 0, ev_on = 0, ev_off = 0, ev_read = 0, ev_foreign = 0;
  logic [CODE_W-1:0] lo_code = '0, hi_code = '0;
  logic vr_en = 0, sel_hi = 0;
  logic smb_on, conv_run, wr_en;
  logic [CODE_W-1:0] act;
  logic [BW-1:0] rd_lo, rd_hi;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  conv_enable_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_setup_i(ev_setup), .ev_on_i(ev_on), .ev_off_i(ev_off),
    .ev_read_i(ev_read), .ev_foreign_i(ev_foreign),
    .setup_lo_code_i(lo_code), .setup_hi_code_i(hi_code),
    .vr_en_i(vr_en), .sel_hi_i(sel_hi),
    .smb_on_o(smb_on), .conv_run_o(conv_run), .reg_wr_en_o(wr_en),
    .active_code_o(act), .rd_lo_byte_o(rd_lo), .rd_hi_byte_o(rd_hi)
  );

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  // Pulse one event for one cycle; inputs change at negedge, results read at next negedge.
  task automatic pulse(input int kind);
    @(negedge clk);
    case (kind)
      0: ev_setup = 1;
      1: ev_on = 1;
      2: ev_off = 1;
      3: ev_read = 1;
      default: ev_foreign = 1;
    endcase
    @(negedge clk);
    ev_setup = 0; ev_on = 0; ev_off = 0; ev_read = 0; ev_foreign = 0;
  endtask

  task automatic do_setup(input logic [4:0] lo, input logic [4:0] hi, input int exp_we, input string req);
    @(negedge clk);
    lo_code = lo; hi_code = hi; ev_setup = 1;
    #1 chk(req, wr_en, exp_we);
    @(negedge clk);
    ev_setup = 0;
  endtask

  task automatic t_reset;
    chk("R1 smb_on", smb_on, 0);
    chk("R1 conv_run", conv_run, 0);
    chk("R1 rd_lo", rd_lo, 8'h04);
    chk("R1 rd_hi", rd_hi, 8'h04);
  endtask

  task automatic t_on_before_setup;
    vr_en = 1;
    pulse(1); pulse(1); pulse(1);
    chk("R6 on ignored", smb_on, 0);
  endtask

  task automatic t_setup_sel;
    do_setup(5'h0A, 5'h15, 1, "R7 wr_en open");
    sel_hi = 0; #1 chk("R8 sel low", act, 5'h0A);
    sel_hi = 1; #1 chk("R8 sel high", act, 5'h15);
    sel_hi = 0;
    chk("R9 rd_lo layout", rd_lo, 8'h54);
    chk("R9 rd_hi layout", rd_hi, 8'hAC);
  endtask

  task automatic t_on_pairs;
    pulse(1); chk("R3 single on", smb_on, 0);
    pulse(3); pulse(1); chk("R3 read breaks", smb_on, 0);
    do_setup(5'h0A, 5'h15, 1, "R7 wr_en open 2");
    pulse(1); chk("R3 setup breaks", smb_on, 0);
    pulse(1); chk("R2 on pair", smb_on, 1);
    chk("R9 run", conv_run, 1);
    chk("R9 status running", rd_lo, 8'h50);
  endtask

  task automatic t_lock;
    do_setup(5'h1F, 5'h00, 0, "R7 locked");
    chk("R7 code kept", act, 5'h0A);
    vr_en = 0;
    #1 chk("R9 run off", conv_run, 0);
    chk("R9 status stopped", rd_lo[2], 1);
    do_setup(5'h03, 5'h0C, 1, "R7 vr low opens");
    chk("R7 loaded", act, 5'h03);
    vr_en = 1;
  endtask

  task automatic t_off_pairs;
    pulse(2); pulse(1); pulse(2);
    chk("R4 on breaks off", smb_on, 1);
    pulse(4); pulse(2);
    chk("R5 foreign keeps off pair", smb_on, 0);
    pulse(1); pulse(4); pulse(1);
    chk("R5 foreign keeps on pair", smb_on, 1);
    pulse(2); pulse(2);
    chk("R4 off pair", smb_on, 0);
    do_setup(5'h11, 5'h12, 1, "R7 off reopens");
    sel_hi = 1; #1 chk("R8 new code", act, 5'h12);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_on_before_setup;
    t_setup_sel;
    t_on_pairs;
    t_lock;
    t_off_pairs;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule